// File: doc/BRIEF.md
# RV32I Fetch and Decode Front-End

This block forms the first two stages of a five-stage RV32I integer pipeline. Its fetch half keeps a program counter. On each enabled clock edge the counter either steps by four or jumps to a supplied branch target. The current counter indexes a word-organised instruction store that is read combinationally. A pipeline register then carries the fetched address and instruction word across to the decode half.

The decode half splits the held instruction into its fields and reads two operands from a 32-entry register file. It also assembles the sign-extended immediate for whichever format the opcode names. Every control input that later stages would normally drive is a plain port here: the two stall enables, the branch select and target, and the write-back port into the register file. A synchronous load port fills the instruction store before a program runs.

Top module: `rv_fetch_decode`

## Requirements
- R1: On a clock edge with `pc_we` high, the fetch address becomes `br_target` when `br_sel` is 1 and the old address plus 4 when `br_sel` is 0.
- R2: On a clock edge with `pc_we` low, the fetch address keeps its value.
- R3: The instruction store holds 2^IMEM_AW 32-bit words and is written synchronously through `im_we`/`im_addr`/`im_wdata`. It is read combinationally at word index `if_pc[IMEM_AW+1:2]`, so `if_pc` bits above IMEM_AW+1 and bits 1:0 do not affect which word is fetched.
- R4: On a clock edge with `ifid_we` high, the pipeline register captures the current fetch address and fetched word. With `ifid_we` low it holds both, so `id_pc` and all decode outputs stay unchanged.
- R5: The register file has 32 entries of 32 bits. On a clock edge with `wb_we` high, entry `wb_rd` takes `wb_data`, and from then on `id_rdata1`/`id_rdata2` return it whenever `id_rs1`/`id_rs2` name that entry.
- R6: Register 0 always reads as zero, and a write-back aimed at it has no effect.
- R7: While `wb_we` is high with a nonzero `wb_rd` equal to a read index, that read port returns `wb_data` in the same cycle.
- R8: The immediate is chosen by opcode. I-format (0000011, 0010011, 1100111) gives bits 31:20 sign-extended. S-format (0100011) gives {31:25, 11:7} sign-extended. B-format (1100011) gives {31, 7, 30:25, 11:8, 0} sign-extended. U-format (0110111, 0010111) gives bits 31:12 followed by twelve zeros. J-format (1101111) gives {31, 19:12, 20, 30:21, 0} sign-extended.
- R9: For any other opcode, including R-format 0110011, the immediate output is zero.
- R10: The decode field outputs are opcode = bits 6:0, rd = 11:7, funct3 = 14:12, rs1 = 19:15, rs2 = 24:20 and funct7 = 31:25 of the held word. `id_pc` is the fetch address captured with it.
- R11: A clock edge with `rst` high sets the fetch address, the held address and the held word to zero. A zero word then decodes to opcode 0 and immediate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Fetch address update enable |
| ifid_we | input | 1 | Pipeline register update enable |
| br_sel | input | 1 | Take the branch target as next address |
| br_target | input | 32 | Branch target address |
| im_we | input | 1 | Instruction store write enable |
| im_addr | input | IMEM_AW (10) | Instruction store word index for loading |
| im_wdata | input | 32 | Instruction word to load |
| wb_we | input | 1 | Register write-back enable |
| wb_rd | input | 5 | Write-back destination register |
| wb_data | input | 32 | Write-back value |
| if_pc | output | 32 | Current fetch address |
| id_pc | output | 32 | Address of the instruction in decode |
| id_opcode | output | 7 | Opcode field |
| id_rd | output | 5 | Destination register field |
| id_rs1 | output | 5 | First source register field |
| id_rs2 | output | 5 | Second source register field |
| id_funct3 | output | 3 | funct3 field |
| id_funct7 | output | 7 | funct7 field |
| id_rdata1 | output | 32 | Operand read at rs1 |
| id_rdata2 | output | 32 | Operand read at rs2 |
| id_imm | output | 32 | Assembled immediate |

## Verification
The fetch address moves one edge after its enables and target are presented. Each decode output reflects, one edge after capture, the word that was fetched in the cycle before that edge. In a free-running stream, the check that follows edge k therefore expects word k-1 in decode and address 4k in fetch. A write-back shows on a read port in the same cycle through the bypass and stays there after the edge. The bench drives inputs and samples outputs one nanosecond after each rising edge. Bypass results are sampled after a further nanosecond with no edge in between.

// File: rtl/rv_fetch_decode.sv
module rv_fetch_decode #(
  parameter int IMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pc_we,
  input  logic               ifid_we,
  input  logic               br_sel,
  input  logic [31:0]        br_target,
  input  logic               im_we,
  input  logic [IMEM_AW-1:0] im_addr,
  input  logic [31:0]        im_wdata,
  input  logic               wb_we,
  input  logic [4:0]         wb_rd,
  input  logic [31:0]        wb_data,
  output logic [31:0]        if_pc,
  output logic [31:0]        id_pc,
  output logic [6:0]         id_opcode,
  output logic [4:0]         id_rd,
  output logic [4:0]         id_rs1,
  output logic [4:0]         id_rs2,
  output logic [2:0]         id_funct3,
  output logic [6:0]         id_funct7,
  output logic [31:0]        id_rdata1,
  output logic [31:0]        id_rdata2,
  output logic [31:0]        id_imm
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_BR    = 7'b1100011;
  localparam logic [6:0] OP_LUI   = 7'b0110111;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_REG   = 7'b0110011;

  logic [31:0] pc_q, pc_next, fetch_word;
  logic [31:0] held_pc, held_ins;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] rf [1:31];

  // fetch
  assign pc_next    = br_sel ? br_target : pc_q + 32'd4;
  assign fetch_word = imem[pc_q[IMEM_AW+1:2]];
  assign if_pc      = pc_q;

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_we) pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (im_we) imem[im_addr] <= im_wdata;
  end

  // fetch/decode register
  always_ff @(posedge clk) begin
    if (rst) begin
      held_pc  <= '0;
      held_ins <= '0;
    end else if (ifid_we) begin
      held_pc  <= pc_q;
      held_ins <= fetch_word;
    end
  end

  // decode fields
  assign id_pc     = held_pc;
  assign id_opcode = held_ins[6:0];
  assign id_rd     = held_ins[11:7];
  assign id_funct3 = held_ins[14:12];
  assign id_rs1    = held_ins[19:15];
  assign id_rs2    = held_ins[24:20];
  assign id_funct7 = held_ins[31:25];

  // register file with write-through
  always_ff @(posedge clk) begin
    if (wb_we && wb_rd != 5'd0) rf[wb_rd] <= wb_data;
  end

  always_comb begin
    id_rdata1 = '0;
    if (id_rs1 != 5'd0)
      id_rdata1 = (wb_we && wb_rd == id_rs1) ? wb_data : rf[id_rs1];
  end

  always_comb begin
    id_rdata2 = '0;
    if (id_rs2 != 5'd0)
      id_rdata2 = (wb_we && wb_rd == id_rs2) ? wb_data : rf[id_rs2];
  end

  // immediate
  always_comb begin
    unique case (id_opcode)
      OP_LOAD, OP_IMM, OP_JALR:
        id_imm = {{20{held_ins[31]}}, held_ins[31:20]};
      OP_STORE:
        id_imm = {{20{held_ins[31]}}, held_ins[31:25], held_ins[11:7]};
      OP_BR:
        id_imm = {{19{held_ins[31]}}, held_ins[31], held_ins[7],
                  held_ins[30:25], held_ins[11:8], 1'b0};
      OP_LUI, OP_AUIPC:
        id_imm = {held_ins[31:12], 12'b0};
      OP_JAL:
        id_imm = {{11{held_ins[31]}}, held_ins[31], held_ins[19:12],
                  held_ins[20], held_ins[30:21], 1'b0};
      default:
        id_imm = '0;
    endcase
  end

  // assertions
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
    (pc_we && !br_sel) |=> (if_pc == $past(if_pc) + 32'd4));

  assert_pc_branch_R1: assert property (@(posedge clk) disable iff (rst)
    (pc_we && br_sel) |=> (if_pc == $past(br_target)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> $stable(if_pc));

  assert_ifid_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ifid_we |=> ($stable(id_pc) && $stable(id_imm) && $stable(id_opcode)));

  assert_ifid_take_R4: assert property (@(posedge clk) disable iff (rst)
    ifid_we |=> (id_pc == $past(if_pc)));

  assert_wb_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_rd != 5'd0 && wb_rd == id_rs1 && !ifid_we) |=>
      ((wb_we && wb_rd == id_rs1) || id_rdata1 == $past(wb_data)));

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == 5'd0) |-> (id_rdata1 == 32'd0));

  assert_upper_low_R8: assert property (@(posedge clk) disable iff (rst)
    (id_opcode == OP_LUI || id_opcode == OP_AUIPC) |-> (id_imm[11:0] == 12'd0));

  assert_regop_imm_R9: assert property (@(posedge clk) disable iff (rst)
    (id_opcode == OP_REG) |-> (id_imm == 32'd0));

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (if_pc == 32'd0 && id_pc == 32'd0 && id_imm == 32'd0));
endmodule

// File: tb/sim_rv_fetch_decode.sv
`timescale 1ns/100ps
module sim_rv_fetch_decode;
  localparam int AW = 10;
  localparam int NPROG = 256;

  logic clk = 1'b0;
  logic rst, pc_we, ifid_we, br_sel, im_we, wb_we;
  logic [31:0] br_target, im_wdata, wb_data;
  logic [AW-1:0] im_addr;
  logic [4:0] wb_rd;
  logic [31:0] if_pc, id_pc, id_rdata1, id_rdata2, id_imm;
  logic [6:0] id_opcode, id_funct7;
  logic [4:0] id_rd, id_rs1, id_rs2;
  logic [2:0] id_funct3;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] prog [NPROG];
  logic [31:0] pimm [NPROG];
  logic [31:0] rf_m [32];

  always #2.5 clk = ~clk;

  rv_fetch_decode #(.IMEM_AW(AW)) u0 (
    .clk(clk), .rst(rst), .pc_we(pc_we), .ifid_we(ifid_we), .br_sel(br_sel),
    .br_target(br_target), .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data), .if_pc(if_pc), .id_pc(id_pc),
    .id_opcode(id_opcode), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_funct3(id_funct3), .id_funct7(id_funct7), .id_rdata1(id_rdata1),
    .id_rdata2(id_rdata2), .id_imm(id_imm)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic build_prog();
    for (int k = 0; k < NPROG; k++) begin
      logic [4:0] kk;
      kk = 5'(k % 32);
      prog[k] = {((k % 2) == 1) ? 7'h20 : 7'h00, 5'(31 - (k % 32)), kk,
                 3'(k % 8), kk, 7'b0110011};
      pimm[k] = 32'd0;
    end
    for (int k = 0; k < 32; k++) begin
      logic [31:0] r;
      logic [11:0] v12;
      logic [12:0] v13;
      logic [19:0] v20;
      logic [20:0] v21;
      logic [6:0]  opc;
      r = 32'(k + 1) * 32'h9E3779B1;
      // I-format
      v12 = (k == 0) ? 12'h800 : (k == 1) ? 12'h7FF : (k == 2) ? 12'hFFF : r[31:20];
      opc = (k % 3 == 0) ? 7'b0000011 : (k % 3 == 1) ? 7'b0010011 : 7'b1100111;
      prog[32+k] = {v12, r[4:0], r[12:10], r[9:5], opc};
      pimm[32+k] = {{20{v12[11]}}, v12};
      // S-format
      v12 = (k == 0) ? 12'h800 : (k == 1) ? 12'h7FF : r[23:12];
      prog[64+k] = {v12[11:5], r[4:0], r[9:5], r[12:10], v12[4:0], 7'b0100011};
      pimm[64+k] = {{20{v12[11]}}, v12};
      // B-format
      v13 = (k == 0) ? 13'h1000 : (k == 1) ? 13'h0FFE : {r[31:20], 1'b0};
      prog[96+k] = {v13[12], v13[10:5], r[4:0], r[9:5], r[12:10], v13[4:1], v13[11], 7'b1100011};
      pimm[96+k] = {{19{v13[12]}}, v13};
      // U-format
      v20 = r[31:12];
      opc = (k % 2 == 0) ? 7'b0110111 : 7'b0010111;
      prog[128+k] = {v20, r[4:0], opc};
      pimm[128+k] = {v20, 12'd0};
      // J-format
      v21 = (k == 0) ? 21'h100000 : (k == 1) ? 21'h0FFFFE : {r[31:12], 1'b0};
      prog[160+k] = {v21[20], v21[10:1], v21[11], v21[19:12], r[4:0], 7'b1101111};
      pimm[160+k] = {{11{v21[20]}}, v21};
    end
    prog[192] = {25'h1FFFFFF, 7'b0001111}; pimm[192] = 32'd0;
    prog[193] = {25'h1FFFFFF, 7'b1110011}; pimm[193] = 32'd0;
    prog[194] = 32'h00108093;              pimm[194] = 32'd1;
    prog[195] = 32'h00802683;              pimm[195] = 32'd8;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1; pc_we = 1; ifid_we = 1; br_sel = 0; br_target = 0;
    im_we = 0; im_addr = 0; im_wdata = 0; wb_we = 0; wb_rd = 0; wb_data = 0;
    build_prog();
    for (int i = 0; i < 32; i++)
      rf_m[i] = (i == 0) ? 32'd0 : (32'(i) * 32'h01010101) ^ 32'hA5A50000;

    #1;
    for (int i = 0; i < NPROG; i++) begin
      im_we = 1; im_addr = AW'(i); im_wdata = prog[i];
      wb_we = (i < 32); wb_rd = 5'(i % 32);
      wb_data = (i == 0) ? 32'hFFFFFFFF : rf_m[i % 32];
      edge1();
    end
    im_we = 0; wb_we = 0;

    // R11 reset state
    chk("R11 if_pc after reset", if_pc, 32'd0);
    chk("R11 id_pc after reset", id_pc, 32'd0);
    chk("R11 imm after reset", id_imm, 32'd0);
    chk("R11 opcode after reset", {25'd0, id_opcode}, 32'd0);

    // free-running sweep: R1 R3 R8 R9 R10 R5 R6
    rst = 0;
    for (int k = 1; k <= 200; k++) begin
      edge1();
      chk("R1 fetch address step", if_pc, 32'(4 * k));
      chk("R10 id_pc", id_pc, 32'(4 * (k - 1)));
      chk("R8 R9 immediate", id_imm, pimm[k-1]);
      chk("R10 opcode", {25'd0, id_opcode}, {25'd0, prog[k-1][6:0]});
      if (k - 1 < 32) begin
        chk("R10 rd", {27'd0, id_rd}, 32'(k - 1));
        chk("R10 rs1", {27'd0, id_rs1}, 32'(k - 1));
        chk("R10 rs2", {27'd0, id_rs2}, 32'(31 - (k - 1)));
        chk("R10 funct3", {29'd0, id_funct3}, 32'((k - 1) % 8));
        chk("R10 funct7", {25'd0, id_funct7}, ((k - 1) % 2 == 1) ? 32'h20 : 32'h0);
        chk("R5 R6 rdata1", id_rdata1, rf_m[k-1]);
        chk("R5 R6 rdata2", id_rdata2, rf_m[31-(k-1)]);
      end
    end

    // R2 / R4 stalls
    pc_we = 0; ifid_we = 1; edge1();
    chk("R2 pc held", if_pc, 32'd800);
    chk("R4 capture with pc stalled", id_pc, 32'd800);
    chk("R4 captured word imm", id_imm, pimm[200]);
    pc_we = 0; ifid_we = 0; edge1();
    chk("R2 pc held again", if_pc, 32'd800);
    chk("R4 id_pc held", id_pc, 32'd800);
    pc_we = 1; ifid_we = 0; edge1();
    chk("R1 pc advances", if_pc, 32'd804);
    chk("R4 id_pc held while pc moves", id_pc, 32'd800);

    // R1 branch redirect
    ifid_we = 1; br_sel = 1; br_target = 32'h100; edge1();
    chk("R1 branch target taken", if_pc, 32'h100);
    chk("R4 id_pc after branch edge", id_pc, 32'd804);
    br_sel = 0; edge1();
    chk("R1 step after branch", if_pc, 32'h104);
    chk("R1 target word in decode", id_pc, 32'h100);
    chk("R8 target word imm", id_imm, pimm[64]);

    // R3 upper address bits ignored
    br_sel = 1; br_target = 32'h0000_1008; edge1();
    chk("R1 wide target", if_pc, 32'h1008);
    br_sel = 0; edge1();
    chk("R3 id_pc wide", id_pc, 32'h1008);
    chk("R3 wraps to word 2 rs1", {27'd0, id_rs1}, 32'd2);
    chk("R3 wraps to word 2 rdata2", id_rdata2, rf_m[29]);

    // R7 / R5 bypass and write-back on word 5
    br_sel = 1; br_target = 32'h14; edge1();
    br_sel = 0; edge1();
    pc_we = 0; ifid_we = 0;
    chk("R10 holding word 5", {27'd0, id_rs1}, 32'd5);
    wb_we = 1; wb_rd = 5'd5; wb_data = 32'hCAFE0005;
    #1;
    chk("R7 bypass rs1", id_rdata1, 32'hCAFE0005);
    chk("R7 other port untouched", id_rdata2, rf_m[26]);
    edge1();
    rf_m[5] = 32'hCAFE0005;
    wb_we = 0;
    #1;
    chk("R5 write landed rs1", id_rdata1, 32'hCAFE0005);
    wb_we = 1; wb_rd = 5'd26; wb_data = 32'h1234_5678;
    #1;
    chk("R7 bypass rs2", id_rdata2, 32'h1234_5678);
    edge1();
    rf_m[26] = 32'h1234_5678;
    wb_we = 1; wb_rd = 5'd9; wb_data = 32'hDEAD_BEEF;
    #1;
    chk("R5 unrelated write rs1", id_rdata1, rf_m[5]);
    chk("R5 unrelated write rs2", id_rdata2, rf_m[26]);
    edge1();
    rf_m[9] = 32'hDEAD_BEEF;
    wb_we = 0;

    // R6 register zero
    pc_we = 1; br_sel = 1; br_target = 32'h0; edge1();
    br_sel = 0; pc_we = 0; ifid_we = 1; edge1();
    ifid_we = 0;
    chk("R10 holding word 0", {27'd0, id_rs2}, 32'd31);
    wb_we = 1; wb_rd = 5'd0; wb_data = 32'hFFFF_FFFF;
    #1;
    chk("R6 zero during write", id_rdata1, 32'd0);
    edge1();
    wb_we = 0;
    #1;
    chk("R6 zero after write", id_rdata1, 32'd0);
    chk("R5 rs2 reg31 value", id_rdata2, rf_m[31]);

    // R5 check reg 9 written earlier via word 9
    pc_we = 1; br_sel = 1; br_target = 32'h24; edge1();
    br_sel = 0; ifid_we = 1; edge1();
    chk("R5 reg9 readback", id_rdata1, 32'hDEAD_BEEF);

    // R11 reset mid-run
    edge1(); edge1();
    rst = 1; edge1();
    chk("R11 pc cleared", if_pc, 32'd0);
    chk("R11 id_pc cleared", id_pc, 32'd0);
    chk("R11 imm cleared", id_imm, 32'd0);
    rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule